// File: doc/BRIEF.md
# Inter-Thread FIFO Storage Cell

This block is one queue-type storage cell shared by several hardware threads. Every access names a thread, says whether it loads or stores, and selects one of four views of the same cell. The bypass view peeks at or patches the queue without moving it. The synchronized view pushes and pops, and stalls the thread when the cell cannot serve it. The try view pushes and pops without ever stalling, and drops or zero-fills instead. The control view reads the cell's tag word and can flush the queue.

A thread that is told to stall keeps a bit set in a per-thread waiting map. The bit is cleared when the cell's state changes in the thread's favour: a push wakes waiting readers, and a pop or flush wakes waiting writers. The thread then retries, and the retry completes only if the cell can now serve it. The tag outputs (empty, full, and a constant queue-type marker) and the waiting map are visible at all times. The response to each access appears one cycle after the request.

Top module: `xthread_fifo_cell`

## Requirements
- R1: After reset the cell is empty (tag_empty=1, tag_full=0), blocked_map is all zero and rsp_valid is 0.
- R2: View 0 (bypass): a load returns the oldest entry without removing it, or 0 when the cell is empty. A store overwrites the newest entry. Neither changes tag_empty or tag_full, and neither stalls.
- R3: Views 1 and 2: a store pushes req_wdata and a load pops and returns the oldest entry, in first-in first-out order. tag_empty and tag_full follow the entry count, and they are never both 1.
- R4: View 1 (synchronized): a load of an empty cell or a store to a full cell returns rsp_block=1 and rsp_rdata=0. It leaves the queue unchanged and sets the thread's bit in blocked_map.
- R5: View 2 (try): rsp_block is always 0. A store to a full cell is dropped, and a load of an empty cell returns 0.
- R6: View 3 (control): a load returns the tag word, with bit 0 = empty, bit 1 = full, bit 2 = queue-type marker (always 1) and all other bits 0. It never stalls. tag_fifo is constantly 1.
- R7: View 3 store: if req_wdata bit 0 is 1, the queue is flushed to empty. All other store bits, including bits 1 and 2, are ignored.
- R8: A push clears the blocked_map bits of threads waiting to load. A pop or a flush clears the bits of threads waiting to store.
- R9: Any access that does not stall clears the issuing thread's blocked_map bit.
- R10: Each accepted request (req_valid=1) produces rsp_valid=1 on the following cycle, with rsp_rdata and rsp_block for that request. Stores return rsp_rdata=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_view | input | 2 | 0 bypass, 1 synchronized, 2 try, 3 control |
| req_tid | input | TID_W | Issuing thread number |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | DATA_W | Load data or tag word |
| rsp_block | output | 1 | Access stalled; the thread must retry |
| tag_empty | output | 1 | Queue holds no entries |
| tag_full | output | 1 | Queue holds DEPTH entries |
| tag_fifo | output | 1 | Queue-type marker, constant 1 |
| blocked_map | output | THREADS | One waiting bit per thread |

## Verification
The bench builds the cell with DEPTH=4 and THREADS=4. Four pushes are then enough to fill the queue, so the full-side cases are all within reach in a short sequence: a dropped try store, a stalled synchronized store, a bypass overwrite of the newest entry while full, and a flush that wakes a waiting writer. Four threads allow a waiting reader, a waiting writer and other threads to be active at the same time. This shows that each wake-up clears only the bits for the matching direction.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

    typedef enum logic [1:0] {
        VIEW_RAW  = 2'd0,
        VIEW_SYNC = 2'd1,
        VIEW_TRY  = 2'd2,
        VIEW_CTRL = 2'd3
    } view_e;

    localparam int TAG_W         = 3;
    localparam int TAG_EMPTY_BIT = 0;
    localparam int TAG_FULL_BIT  = 1;
    localparam int TAG_TYPE_BIT  = 2;

    // Decoded effect of one access on the cell
    typedef struct packed {
        logic push;       // append store data
        logic pop;        // drop oldest entry
        logic amend;      // overwrite newest entry in place
        logic flush;      // discard all entries
        logic stall;      // thread must wait and retry
        logic stall_wr;   // stall came from a store
        logic done;       // access completed
        logic take_head;  // load returns the oldest entry
        logic take_tag;   // load returns the tag word
    } action_t;

    function automatic logic [TAG_W-1:0] make_tag(input logic empty, input logic full);
        logic [TAG_W-1:0] t;
        t                = '0;
        t[TAG_EMPTY_BIT] = empty;
        t[TAG_FULL_BIT]  = full;
        t[TAG_TYPE_BIT]  = 1'b1;
        return t;
    endfunction

endpackage

// File: rtl/xfc_queue.sv
module xfc_queue #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic              amend,
    input  logic              flush,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  count;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_prev(input logic [PTR_W-1:0] p);
        return (p == '0) ? LAST : p - 1'b1;
    endfunction

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (push)  mem[wr_ptr] <= wdata;
        if (amend) mem[ptr_prev(wr_ptr)] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            rd_ptr <= wr_ptr;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/xfc_view_decode.sv
module xfc_view_decode
    import xfc_pkg::*;
(
    input  logic    valid,
    input  logic    write,
    input  logic [1:0] view,
    input  logic    flush_bit,
    input  logic    empty,
    input  logic    full,
    output action_t act
);
    view_e v;
    assign v = view_e'(view);

    always_comb begin
        act = '0;
        if (valid) begin
            unique case (v)
                VIEW_RAW: begin
                    act.amend     = write;
                    act.take_head = !write && !empty;
                end
                VIEW_SYNC: begin
                    if (write) begin
                        act.stall    = full;
                        act.stall_wr = full;
                        act.push     = !full;
                    end else begin
                        act.stall     = empty;
                        act.pop       = !empty;
                        act.take_head = !empty;
                    end
                end
                VIEW_TRY: begin
                    if (write) begin
                        act.push = !full;
                    end else begin
                        act.pop       = !empty;
                        act.take_head = !empty;
                    end
                end
                VIEW_CTRL: begin
                    act.flush    = write && flush_bit;
                    act.take_tag = !write;
                end
                default: ;
            endcase
            act.done = !act.stall;
        end
    end
endmodule

// File: rtl/xfc_wait_map.sv
module xfc_wait_map #(
    parameter int THREADS = 4,
    parameter int TID_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [TID_W-1:0]   tid,
    input  logic               stall,
    input  logic               stall_wr,
    input  logic               done,
    input  logic               wake_readers,
    input  logic               wake_writers,
    output logic [THREADS-1:0] map
);
    for (genvar t = 0; t < THREADS; t++) begin : g_thread
        logic rd_wait, wr_wait, mine;
        assign mine   = (tid == TID_W'(t));
        assign map[t] = rd_wait | wr_wait;

        always_ff @(posedge clk) begin
            if (rst) begin
                rd_wait <= 1'b0;
                wr_wait <= 1'b0;
            end else if (mine && stall) begin
                rd_wait <= !stall_wr;
                wr_wait <= stall_wr;
            end else if (mine && done) begin
                rd_wait <= 1'b0;
                wr_wait <= 1'b0;
            end else begin
                if (wake_readers) rd_wait <= 1'b0;
                if (wake_writers) wr_wait <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/xthread_fifo_cell.sv
module xthread_fifo_cell
    import xfc_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int DATA_W  = 32,
    parameter int THREADS = 4,
    localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         req_view,
    input  logic [TID_W-1:0]   req_tid,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               rsp_block,
    output logic               tag_empty,
    output logic               tag_full,
    output logic               tag_fifo,
    output logic [THREADS-1:0] blocked_map
);
    action_t           act;
    logic [DATA_W-1:0] head;
    logic [DATA_W-1:0] rdata_next;

    xfc_view_decode u_decode (
        .valid     (req_valid),
        .write     (req_write),
        .view      (req_view),
        .flush_bit (req_wdata[0]),
        .empty     (tag_empty),
        .full      (tag_full),
        .act       (act)
    );

    xfc_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .push  (act.push),
        .pop   (act.pop),
        .amend (act.amend),
        .flush (act.flush),
        .wdata (req_wdata),
        .head  (head),
        .empty (tag_empty),
        .full  (tag_full)
    );

    xfc_wait_map #(.THREADS(THREADS), .TID_W(TID_W)) u_wait (
        .clk          (clk),
        .rst          (rst),
        .tid          (req_tid),
        .stall        (act.stall),
        .stall_wr     (act.stall_wr),
        .done         (act.done),
        .wake_readers (act.push),
        .wake_writers (act.pop | act.flush),
        .map          (blocked_map)
    );

    assign tag_fifo = 1'b1;

    always_comb begin
        rdata_next = '0;
        if (act.take_head)
            rdata_next = head;
        else if (act.take_tag)
            rdata_next = DATA_W'(make_tag(tag_empty, tag_full));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_block <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= rdata_next;
            rsp_block <= act.stall;
        end
    end
endmodule

// File: rtl/xfc_checker.sv
module xfc_checker #(
    parameter int THREADS = 4,
    parameter int TID_W   = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_write,
    input logic [1:0]         req_view,
    input logic [TID_W-1:0]   req_tid,
    input logic               req_flush,
    input logic               rsp_valid,
    input logic               rsp_block,
    input logic               tag_empty,
    input logic               tag_full,
    input logic [THREADS-1:0] blocked_map
);
    p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        !(tag_empty && tag_full));

    p_raw_store_keeps_flags_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_view == 2'd0)
        |=> ($stable(tag_empty) && $stable(tag_full) && !rsp_block));

    p_try_never_stalls_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_view == 2'd2) |=> !rsp_block);

    p_ctrl_never_stalls_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_view == 2'd3) |=> !rsp_block);

    p_flush_empties_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_view == 2'd3 && req_flush) |=> tag_empty);

    p_stall_marks_thread_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_block) |-> blocked_map[$past(req_tid)]);

    p_done_clears_thread_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_block) |-> !blocked_map[$past(req_tid)]);

    p_response_follows_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
endmodule

bind xthread_fifo_cell xfc_checker #(.THREADS(THREADS), .TID_W(TID_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_view    (req_view),
    .req_tid     (req_tid),
    .req_flush   (req_wdata[0]),
    .rsp_valid   (rsp_valid),
    .rsp_block   (rsp_block),
    .tag_empty   (tag_empty),
    .tag_full    (tag_full),
    .blocked_map (blocked_map)
);

// File: tb/xthread_fifo_cell_tb.sv
module xthread_fifo_cell_tb;
    localparam int DEPTH   = 4;
    localparam int DATA_W  = 32;
    localparam int THREADS = 4;
    localparam int TID_W   = 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               req_valid = 1'b0;
    logic               req_write = 1'b0;
    logic [1:0]         req_view  = '0;
    logic [TID_W-1:0]   req_tid   = '0;
    logic [DATA_W-1:0]  req_wdata = '0;
    logic               rsp_valid, rsp_block, tag_empty, tag_full, tag_fifo;
    logic [DATA_W-1:0]  rsp_rdata;
    logic [THREADS-1:0] blocked_map;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    xthread_fifo_cell #(.DEPTH(DEPTH), .DATA_W(DATA_W), .THREADS(THREADS)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_view(req_view), .req_tid(req_tid), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_block(rsp_block),
        .tag_empty(tag_empty), .tag_full(tag_full), .tag_fifo(tag_fifo),
        .blocked_map(blocked_map)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  view;
        logic [1:0]  tid;
        logic [31:0] wd;
        logic [31:0] er;
        logic        eb;
        logic        ee;
        logic        ef;
        logic [3:0]  em;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd3, 2'd0, 32'h0,  32'h5,  1'b0, 1'b1, 1'b0, 4'b0000}, // 0  R6 tag of empty cell
        '{1'b0, 2'd1, 2'd1, 32'h0,  32'h0,  1'b1, 1'b1, 1'b0, 4'b0010}, // 1  R4 load empty stalls
        '{1'b0, 2'd3, 2'd1, 32'h0,  32'h5,  1'b0, 1'b1, 1'b0, 4'b0000}, // 2  R9 other access clears bit
        '{1'b0, 2'd1, 2'd1, 32'h0,  32'h0,  1'b1, 1'b1, 1'b0, 4'b0010}, // 3  R4 stall again
        '{1'b0, 2'd2, 2'd2, 32'h0,  32'h0,  1'b0, 1'b1, 1'b0, 4'b0010}, // 4  R5 try load empty
        '{1'b1, 2'd1, 2'd0, 32'hA1, 32'h0,  1'b0, 1'b0, 1'b0, 4'b0000}, // 5  R8 push wakes reader
        '{1'b0, 2'd1, 2'd1, 32'h0,  32'hA1, 1'b0, 1'b1, 1'b0, 4'b0000}, // 6  R3 retry pops
        '{1'b1, 2'd2, 2'd0, 32'hB1, 32'h0,  1'b0, 1'b0, 1'b0, 4'b0000}, // 7  R3 fill
        '{1'b1, 2'd2, 2'd0, 32'hB2, 32'h0,  1'b0, 1'b0, 1'b0, 4'b0000}, // 8  R3
        '{1'b1, 2'd2, 2'd0, 32'hB3, 32'h0,  1'b0, 1'b0, 1'b0, 4'b0000}, // 9  R3
        '{1'b1, 2'd2, 2'd0, 32'hB4, 32'h0,  1'b0, 1'b0, 1'b1, 4'b0000}, // 10 R3 full
        '{1'b1, 2'd2, 2'd0, 32'hB5, 32'h0,  1'b0, 1'b0, 1'b1, 4'b0000}, // 11 R5 dropped store
        '{1'b0, 2'd3, 2'd2, 32'h0,  32'h6,  1'b0, 1'b0, 1'b1, 4'b0000}, // 12 R6 tag of full cell
        '{1'b1, 2'd1, 2'd3, 32'hC1, 32'h0,  1'b1, 1'b0, 1'b1, 4'b1000}, // 13 R4 store full stalls
        '{1'b0, 2'd0, 2'd2, 32'h0,  32'hB1, 1'b0, 1'b0, 1'b1, 4'b1000}, // 14 R2 peek oldest
        '{1'b1, 2'd0, 2'd2, 32'hD4, 32'h0,  1'b0, 1'b0, 1'b1, 4'b1000}, // 15 R2 amend newest
        '{1'b0, 2'd1, 2'd0, 32'h0,  32'hB1, 1'b0, 1'b0, 1'b0, 4'b0000}, // 16 R8 pop wakes writer
        '{1'b1, 2'd1, 2'd3, 32'hC1, 32'h0,  1'b0, 1'b0, 1'b1, 4'b0000}, // 17 R9 retry completes
        '{1'b0, 2'd2, 2'd1, 32'h0,  32'hB2, 1'b0, 1'b0, 1'b0, 4'b0000}, // 18 R3 order
        '{1'b0, 2'd2, 2'd1, 32'h0,  32'hB3, 1'b0, 1'b0, 1'b0, 4'b0000}, // 19 R3
        '{1'b0, 2'd2, 2'd1, 32'h0,  32'hD4, 1'b0, 1'b0, 1'b0, 4'b0000}, // 20 R2 amended value
        '{1'b0, 2'd2, 2'd1, 32'h0,  32'hC1, 1'b0, 1'b1, 1'b0, 4'b0000}, // 21 R3 drained
        '{1'b0, 2'd2, 2'd1, 32'h0,  32'h0,  1'b0, 1'b1, 1'b0, 4'b0000}, // 22 R5 try load empty
        '{1'b0, 2'd0, 2'd0, 32'h0,  32'h0,  1'b0, 1'b1, 1'b0, 4'b0000}, // 23 R2 peek empty
        '{1'b1, 2'd0, 2'd0, 32'h77, 32'h0,  1'b0, 1'b1, 1'b0, 4'b0000}, // 24 R2 amend empty
        '{1'b1, 2'd1, 2'd2, 32'hE1, 32'h0,  1'b0, 1'b0, 1'b0, 4'b0000}, // 25 R3 push
        '{1'b1, 2'd3, 2'd0, 32'h6,  32'h0,  1'b0, 1'b0, 1'b0, 4'b0000}, // 26 R7 other bits ignored
        '{1'b1, 2'd3, 2'd0, 32'h1,  32'h0,  1'b0, 1'b1, 1'b0, 4'b0000}, // 27 R7 flush
        '{1'b0, 2'd0, 2'd0, 32'h0,  32'h0,  1'b0, 1'b1, 1'b0, 4'b0000}  // 28 R7 nothing left
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [1:0] view, input logic [1:0] tid,
                          input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_view  = view;
        req_tid   = tid;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        req_wdata = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 reset empty/full/map/valid",
              {60'd0, tag_empty, tag_full, rsp_valid, |blocked_map}, {60'd0, 4'b1000});
        check("R6 type marker", {63'd0, tag_fifo}, 64'd1);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].view, VECS[i].tid, VECS[i].wd);
            // R10 response one cycle after request
            check($sformatf("R10 vec%0d rsp_valid", i), {63'd0, rsp_valid}, 64'd1);
            check($sformatf("vec%0d rdata/block/empty/full/map", i),
                  {21'd0, rsp_rdata, rsp_block, tag_empty, tag_full, blocked_map},
                  {21'd0, VECS[i].er, VECS[i].eb, VECS[i].ee, VECS[i].ef, VECS[i].em});
        end

        // R10 no response on an idle cycle
        @(negedge clk);
        check("R10 idle rsp_valid", {63'd0, rsp_valid}, 64'd0);

        // R8 flush wakes a waiting writer
        for (int k = 0; k < DEPTH; k++) access(1'b1, 2'd2, 2'd0, 32'h100 + k);
        check("R3 full after DEPTH pushes", {62'd0, tag_empty, tag_full}, 64'b01);
        access(1'b1, 2'd1, 2'd1, 32'h200);
        check("R4 writer waits", {60'd0, blocked_map}, 64'b0010);
        access(1'b0, 2'd1, 2'd2, 32'h0);
        check("R8 pop wakes writer, R3 oldest popped",
              {28'd0, rsp_rdata, blocked_map}, {28'd0, 32'h100, 4'b0000});
        access(1'b1, 2'd1, 2'd3, 32'h300);
        access(1'b1, 2'd1, 2'd1, 32'h201);
        check("R4 second writer waits", {60'd0, blocked_map}, 64'b0010);
        access(1'b1, 2'd3, 2'd0, 32'h1);
        check("R8 flush wakes writer, R7 empty",
              {58'd0, tag_empty, tag_full, blocked_map}, {58'd0, 2'b10, 4'b0000});

        // R1 reset in mid-operation
        access(1'b0, 2'd1, 2'd3, 32'h0);
        access(1'b1, 2'd2, 2'd0, 32'h55);
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b1;
        req_view  = 2'd1;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset clears state",
              {60'd0, tag_empty, tag_full, rsp_valid, |blocked_map}, {60'd0, 4'b1000});
        access(1'b0, 2'd2, 2'd0, 32'h0);
        check("R1 queue empty after reset", {32'd0, rsp_rdata}, 64'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule